// File: doc/BRIEF.md
# Prioritized UART Interrupt Controller

This block is the interrupt logic of a single UART channel. It watches four kinds of pending condition: a receive line error, receive data waiting (or a receive timeout), the transmit holding register going empty, and a change on any modem input. Each kind is gated by one bit of a four-bit enable mask. The highest-priority enabled condition is reported as a four-bit status code. A registered interrupt line goes high whenever any enabled condition is pending.

Clearing is driven by register-access strobes that the surrounding register file produces. These are a read of line status, a read of the interrupt status, a write of the transmit holding register, and a read of modem status. The interrupt pin has a separate output-enable. Software turns it on through a gate bit, and a continuous-enable input keeps it driven permanently.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset the status code is 4'h1 (nothing pending), the interrupt output is 0 and all four modem delta bits are 0.
- R2: The status code reports one source by fixed priority, highest first: line error 4'h6, receive (data 4'h4 or timeout 4'hC), transmit empty 4'h2, modem change 4'h0. Bit 0 of the code is 0 exactly when a source is reported.
- R3: Enable mask bit 0 gates receive, bit 1 transmit empty, bit 2 line error and bit 3 modem change. A masked source is never reported, and its latched pending state is kept while it is masked.
- R4: Receive is reported only while mask bit 0 is set. The timeout code 4'hC appears only while the FIFO-enable input is 1 and the timeout input is high, and it takes precedence over 4'h4. Otherwise a high data-available input gives 4'h4.
- R5: A line-error event strobe latches a line pending state. A line-status read strobe clears it.
- R6: A transmit-empty event strobe latches a transmit pending state. It is cleared by a holding-register write strobe, or by an interrupt-status read strobe in a cycle where the reported code is 4'h2. An interrupt-status read while another code is reported leaves it set.
- R7: Each modem change strobe bit sets the matching delta bit. Any set delta bit makes the modem source pending. A modem-status read strobe clears all delta bits.
- R8: The interrupt output is registered. It equals, one clock later, whether the status code showed a pending source.
- R9: The interrupt output-enable is 1 when the gate input is 1 or the continuous-enable input is 1, and 0 otherwise.
- R10: When a set strobe and its clear strobe arrive in the same cycle, the pending state ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_mask_i | input | 4 | Source enable mask |
| fifo_on_i | input | 1 | FIFO mode enable, qualifies the receive timeout |
| rx_avail_i | input | 1 | Receive data available (level) |
| rx_tmo_i | input | 1 | Receive timeout (level) |
| line_err_evt_i | input | 1 | Line error event strobe |
| thr_empty_evt_i | input | 1 | Transmit holding register became empty, strobe |
| thr_wr_i | input | 1 | Transmit holding register write strobe |
| modem_chg_i | input | 4 | Per-line modem input change strobes |
| lsr_rd_i | input | 1 | Line status read strobe |
| isr_rd_i | input | 1 | Interrupt status read strobe |
| msr_rd_i | input | 1 | Modem status read strobe |
| out_gate_i | input | 1 | Software gate for the interrupt pin drive |
| cont_en_i | input | 1 | Continuous pin-drive enable |
| status_o | output | 4 | Encoded interrupt status |
| delta_o | output | 4 | Modem delta bits |
| irq_o | output | 1 | Registered interrupt, active high |
| irq_oe_o | output | 1 | Output-enable for the interrupt pin |

## Verification
Directed sequences first raise several sources together and then clear them one at a time. This shows that the encoder falls through the priority levels in order and not merely to some pending source. Further directed steps cover:
- a masked source that is later unmasked, which separates reporting-time masking from masking at latch time;
- an interrupt-status read while a higher source hides the transmit code, which tells a conditional clear from an unconditional one;
- same-cycle set and clear, which fixes the set-wins rule.

A long random run with sparse strobes and changing mask and level inputs is then compared every cycle against a bench model. It covers the one-cycle interrupt lag and the pin-enable combinations.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int STAT_W  = 4;
    localparam int N_SRC   = 4;
    localparam int N_DELTA = 4;

    // enable mask bit positions
    localparam int EN_RX    = 0;
    localparam int EN_TX    = 1;
    localparam int EN_LINE  = 2;
    localparam int EN_MODEM = 3;

    typedef enum logic [STAT_W-1:0] {
        IC_MODEM   = 4'h0,
        IC_NONE    = 4'h1,
        IC_TXEMPTY = 4'h2,
        IC_RXDATA  = 4'h4,
        IC_LINE    = 4'h6,
        IC_RXTMO   = 4'hC
    } irq_code_e;

endpackage

// File: rtl/uart_irq_src.sv
module uart_irq_src #(
    parameter int N_DELTA = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               line_set_i,
    input  logic               line_clr_i,
    input  logic               tx_set_i,
    input  logic               tx_clr_i,
    input  logic [N_DELTA-1:0] chg_i,
    input  logic               delta_clr_i,
    output logic               line_o,
    output logic               tx_o,
    output logic [N_DELTA-1:0] delta_o
);

    typedef struct packed {
        logic               line;
        logic               tx;
        logic [N_DELTA-1:0] delta;
    } src_t;

    src_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // clear first, then set: a set in the same cycle wins
        if (line_clr_i) st_d.line = 1'b0;
        if (line_set_i) st_d.line = 1'b1;
        if (tx_clr_i)   st_d.tx   = 1'b0;
        if (tx_set_i)   st_d.tx   = 1'b1;
        if (delta_clr_i) st_d.delta = '0;
        st_d.delta = st_d.delta | chg_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign line_o  = st_q.line;
    assign tx_o    = st_q.tx;
    assign delta_o = st_q.delta;

endmodule

// File: rtl/uart_irq_pri.sv
module uart_irq_pri
    import uart_irq_pkg::*;
(
    input  logic [N_SRC-1:0]  en_i,
    input  logic              fifo_on_i,
    input  logic              line_i,
    input  logic              rx_avail_i,
    input  logic              rx_tmo_i,
    input  logic              tx_i,
    input  logic              modem_i,
    output logic [STAT_W-1:0] code_o
);

    logic rx_tmo_q;
    logic [N_SRC-1:0] req;
    irq_code_e lvl_code [N_SRC];

    assign rx_tmo_q = rx_tmo_i & fifo_on_i;

    // index 0 is the highest priority
    assign req[0] = line_i  & en_i[EN_LINE];
    assign req[1] = (rx_avail_i | rx_tmo_q) & en_i[EN_RX];
    assign req[2] = tx_i    & en_i[EN_TX];
    assign req[3] = modem_i & en_i[EN_MODEM];

    assign lvl_code[0] = IC_LINE;
    assign lvl_code[1] = rx_tmo_q ? IC_RXTMO : IC_RXDATA;
    assign lvl_code[2] = IC_TXEMPTY;
    assign lvl_code[3] = IC_MODEM;

    always_comb begin
        code_o = IC_NONE;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (req[i]) code_o = lvl_code[i];
        end
    end

endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
    import uart_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_SRC-1:0]   en_mask_i,
    input  logic               fifo_on_i,
    input  logic               rx_avail_i,
    input  logic               rx_tmo_i,
    input  logic               line_err_evt_i,
    input  logic               thr_empty_evt_i,
    input  logic               thr_wr_i,
    input  logic [N_DELTA-1:0] modem_chg_i,
    input  logic               lsr_rd_i,
    input  logic               isr_rd_i,
    input  logic               msr_rd_i,
    input  logic               out_gate_i,
    input  logic               cont_en_i,
    output logic [STAT_W-1:0]  status_o,
    output logic [N_DELTA-1:0] delta_o,
    output logic               irq_o,
    output logic               irq_oe_o
);

    typedef struct packed {
        logic irq;
    } out_t;

    out_t o_d, o_q;
    logic line_p, tx_p;
    logic [N_DELTA-1:0] delta;
    logic [STAT_W-1:0] code;
    logic tx_rd_clr;

    assign tx_rd_clr = isr_rd_i & (code == IC_TXEMPTY);

    uart_irq_src #(.N_DELTA(N_DELTA)) i_src (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_set_i  (line_err_evt_i),
        .line_clr_i  (lsr_rd_i),
        .tx_set_i    (thr_empty_evt_i),
        .tx_clr_i    (thr_wr_i | tx_rd_clr),
        .chg_i       (modem_chg_i),
        .delta_clr_i (msr_rd_i),
        .line_o      (line_p),
        .tx_o        (tx_p),
        .delta_o     (delta)
    );

    uart_irq_pri i_pri (
        .en_i       (en_mask_i),
        .fifo_on_i  (fifo_on_i),
        .line_i     (line_p),
        .rx_avail_i (rx_avail_i),
        .rx_tmo_i   (rx_tmo_i),
        .tx_i       (tx_p),
        .modem_i    (|delta),
        .code_o     (code)
    );

    always_comb begin
        o_d     = o_q;
        o_d.irq = ~code[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign status_o = code;
    assign delta_o  = delta;
    assign irq_o    = o_q.irq;
    assign irq_oe_o = out_gate_i | cont_en_i;

endmodule

// File: rtl/uart_irq_chk.sv
module uart_irq_chk
    import uart_irq_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               fifo_on_i,
    input logic               line_err_evt_i,
    input logic               lsr_rd_i,
    input logic               thr_empty_evt_i,
    input logic               thr_wr_i,
    input logic [N_DELTA-1:0] modem_chg_i,
    input logic               msr_rd_i,
    input logic               cont_en_i,
    input logic [STAT_W-1:0]  status_o,
    input logic [N_DELTA-1:0] delta_o,
    input logic               irq_o,
    input logic               irq_oe_o
);

    logic past_ok;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    p_code_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o == IC_NONE || status_o == IC_LINE || status_o == IC_RXDATA ||
         status_o == IC_RXTMO || status_o == IC_TXEMPTY || status_o == IC_MODEM));

    p_tmo_needs_fifo_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_on_i |-> status_o != IC_RXTMO);

    p_line_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (lsr_rd_i && !line_err_evt_i) |=> status_o != IC_LINE);

    p_tx_wr_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_wr_i && !thr_empty_evt_i) |=> status_o != IC_TXEMPTY);

    p_delta_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|modem_chg_i) |=> (|delta_o));

    p_delta_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (msr_rd_i && modem_chg_i == '0) |=> delta_o == '0);

    p_irq_lag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> irq_o == $past(status_o != IC_NONE));

    p_cont_drive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cont_en_i |-> irq_oe_o);

endmodule

bind uart_irq_ctrl uart_irq_chk i_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .fifo_on_i       (fifo_on_i),
    .line_err_evt_i  (line_err_evt_i),
    .lsr_rd_i        (lsr_rd_i),
    .thr_empty_evt_i (thr_empty_evt_i),
    .thr_wr_i        (thr_wr_i),
    .modem_chg_i     (modem_chg_i),
    .msr_rd_i        (msr_rd_i),
    .cont_en_i       (cont_en_i),
    .status_o        (status_o),
    .delta_o         (delta_o),
    .irq_o           (irq_o),
    .irq_oe_o        (irq_oe_o)
);

// File: tb/test_uart_irq_ctrl.sv
`timescale 1ns/1ps
module test_uart_irq_ctrl;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] en_mask;
    logic       fifo_on, rx_avail, rx_tmo;
    logic       line_evt, thr_evt, thr_wr;
    logic [3:0] chg;
    logic       lsr_rd, isr_rd, msr_rd, gate, cont;
    logic [3:0] status, delta;
    logic       irq, irq_oe;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    // bench model state
    logic       m_line, m_tx, m_irq;
    logic [3:0] m_delta;

    always #2 clk = ~clk;

    uart_irq_ctrl i_uart_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .en_mask_i(en_mask), .fifo_on_i(fifo_on),
        .rx_avail_i(rx_avail), .rx_tmo_i(rx_tmo), .line_err_evt_i(line_evt),
        .thr_empty_evt_i(thr_evt), .thr_wr_i(thr_wr), .modem_chg_i(chg),
        .lsr_rd_i(lsr_rd), .isr_rd_i(isr_rd), .msr_rd_i(msr_rd),
        .out_gate_i(gate), .cont_en_i(cont), .status_o(status),
        .delta_o(delta), .irq_o(irq), .irq_oe_o(irq_oe)
    );

    function automatic logic [3:0] exp_code(input logic ln, input logic tx,
                                            input logic [3:0] dl);
        if (ln && en_mask[2]) return 4'h6;
        if (en_mask[0] && rx_tmo && fifo_on) return 4'hC;
        if (en_mask[0] && rx_avail) return 4'h4;
        if (tx && en_mask[1]) return 4'h2;
        if ((|dl) && en_mask[3]) return 4'h0;
        return 4'h1;
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic clear_strobes();
        line_evt = 0; thr_evt = 0; thr_wr = 0; chg = 0;
        lsr_rd = 0; isr_rd = 0; msr_rd = 0;
    endtask

    // inputs are set at a negedge before the call
    task automatic step(input string tag);
        logic [3:0] cur;
        @(posedge clk);
        cur     = exp_code(m_line, m_tx, m_delta);
        m_irq   = (cur != 4'h1);
        m_line  = line_evt | (m_line & ~lsr_rd);
        m_tx    = thr_evt | (m_tx & ~(thr_wr | (isr_rd && cur == 4'h2)));
        m_delta = chg | (m_delta & {4{~msr_rd}});
        @(negedge clk);
        check(tag, "status", status, exp_code(m_line, m_tx, m_delta));
        check(tag, "irq", {3'b0, irq}, {3'b0, m_irq});
        check(tag, "delta", delta, m_delta);
        check(tag, "irq_oe", {3'b0, irq_oe}, {3'b0, gate | cont});
        clear_strobes();
    endtask

    initial begin
        while (cycles < 200000) begin
            @(posedge clk);
            cycles++;
        end
        fails++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        rst_n = 0; en_mask = 0; fifo_on = 0; rx_avail = 0; rx_tmo = 0;
        gate = 0; cont = 0;
        clear_strobes();
        m_line = 0; m_tx = 0; m_irq = 0; m_delta = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        check("R1", "status", status, 4'h1);
        check("R1", "irq", {3'b0, irq}, 4'h0);
        check("R1", "delta", delta, 4'h0);

        // R3: masked line error is latched but not reported
        @(negedge clk);
        line_evt = 1; step("R3");
        check("R3", "masked status", status, 4'h1);
        step("R3");
        check("R3", "masked irq", {3'b0, irq}, 4'h0);
        en_mask = 4'hF; step("R3");
        check("R3", "unmask reveals line", status, 4'h6);

        // R2: stack all sources, then peel off in priority order
        rx_avail = 1; thr_evt = 1; chg = 4'b0100; step("R2");
        check("R2", "line first", status, 4'h6);
        check("R8", "irq high", {3'b0, irq}, 4'h1);
        // R6: isr read while line reported keeps tx pending
        isr_rd = 1; step("R6");
        lsr_rd = 1; step("R5");
        check("R5", "line cleared", status, 4'h4);
        // R4: timeout needs fifo mode
        rx_tmo = 1; step("R4");
        check("R4", "no fifo no tmo", status, 4'h4);
        fifo_on = 1; step("R4");
        check("R4", "tmo code", status, 4'hC);
        rx_avail = 0; rx_tmo = 0; step("R2");
        check("R6", "tx kept after other-source read", status, 4'h2);
        isr_rd = 1; step("R6");
        check("R6", "tx cleared by status read", status, 4'h0);
        check("R7", "delta bit", delta, 4'b0100);
        msr_rd = 1; step("R7");
        check("R7", "delta cleared", delta, 4'h0);
        check("R2", "none", status, 4'h1);
        step("R8");
        check("R8", "irq low one clock later", {3'b0, irq}, 4'h0);

        // R10: set and clear together
        line_evt = 1; lsr_rd = 1; step("R10");
        check("R10", "line set wins", status, 4'h6);
        lsr_rd = 1; step("R5");
        thr_evt = 1; thr_wr = 1; step("R10");
        check("R10", "tx set wins", status, 4'h2);
        thr_wr = 1; step("R6");
        check("R6", "tx cleared by write", status, 4'h1);
        chg = 4'b0001; msr_rd = 1; step("R10");
        check("R10", "delta set wins", delta, 4'b0001);
        msr_rd = 1; step("R7");

        // R9: pin enable combinations
        gate = 1; cont = 0; step("R9");
        gate = 0; cont = 1; step("R9");
        gate = 0; cont = 0; step("R9");
        check("R9", "oe off", {3'b0, irq_oe}, 4'h0);

        // random phase
        for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(0, 15) == 0) en_mask = 4'($urandom);
            if ($urandom_range(0, 7) == 0) fifo_on = 1'($urandom);
            if ($urandom_range(0, 5) == 0) rx_avail = 1'($urandom);
            if ($urandom_range(0, 5) == 0) rx_tmo = 1'($urandom);
            if ($urandom_range(0, 9) == 0) begin gate = 1'($urandom); cont = 1'($urandom); end
            line_evt = ($urandom_range(0, 7) == 0);
            thr_evt  = ($urandom_range(0, 5) == 0);
            thr_wr   = ($urandom_range(0, 7) == 0);
            chg      = ($urandom_range(0, 7) == 0) ? 4'($urandom) : 4'h0;
            lsr_rd   = ($urandom_range(0, 5) == 0);
            isr_rd   = ($urandom_range(0, 3) == 0);
            msr_rd   = ($urandom_range(0, 5) == 0);
            step("R2");
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule